// File: doc/BRIEF.md
# Fixed 64 KB Main Memory Region Decoder

This block sits between a processor's byte-wide memory request and the memory arrays and I/O devices of a fixed 64 KB main memory map. For each byte cycle it decides which region the address falls in and the offset inside that region. It raises a read or write strobe toward that region only when the access is allowed.

The map holds the following regions:

- lower and upper main RAM;
- a BASIC ROM that overlays upper RAM;
- a work RAM page;
- a RAM page shared with a sub-processor;
- the I/O page;
- a 512-byte boot area whose image comes from a boot-mode code;
- a writable vector RAM;
- a hardwired two-byte reset vector.

An initiator ROM can be switched in over two address ranges.

Requests are either single bytes or 16-bit words. A word access runs as two byte cycles through the same decoder, with the most significant byte at the lower address. The result comes back on a one-cycle acknowledge. Some reads never touch memory: the reset vector, and shared RAM while the sub-processor runs. The block answers those with constants of its own.

Top module: `mem_region_decoder`

## Requirements
- R1: Addresses 0x0000 to 0x7FFF select lower RAM (region code 1) with offset equal to the address.
- R2: Addresses 0x8000 to 0xFBFF use offset address minus 0x8000. They select upper RAM (code 2) when `rom_sel` is 0. They select BASIC ROM (code 3) when `rom_sel` is 1, and a write to BASIC ROM raises no write strobe.
- R3: Addresses 0xFC00 to 0xFC7F select work RAM (code 4) with offset address minus 0xFC00. Addresses 0xFC80 to 0xFCFF select shared RAM (code 5) with offset equal to address bits 6:0.
- R4: While `sub_halted` is 0, a shared-RAM read raises no read strobe and returns 0xFF, and a shared-RAM write raises no write strobe.
- R5: Addresses 0xFD00 to 0xFDFF select the I/O page (code 6) with offset equal to address bits 7:0. Both reads and writes are strobed.
- R6: Addresses 0xFE00 to 0xFFDF select a boot image, with offset address minus 0xFE00. `boot_mode` 0 selects BASIC (code 7), 1 selects DOS (code 8), 2 selects mapper (code 9) and 3 selects RAM (code 10). Codes 4 to 7 fall back to BASIC. Only the RAM image accepts writes.
- R7: Addresses 0xFFE0 to 0xFFFD select vector RAM (code 11) with offset address minus 0xFFE0. It is readable and writable.
- R8: Addresses 0xFFFE and 0xFFFF select the reset vector (code 12) with offset 0 and 1. A read returns 0xFE and 0x00 respectively without a read strobe, and a write raises no strobe.
- R9: While `init_en` is 1, two ranges select the initiator ROM (code 13) and never accept writes. 0x6000 to 0x7FFF does so at offset address minus 0x6000. 0xE000 to 0xFFFF, except the I/O page 0xFD00 to 0xFDFF, does so at offset address minus 0xE000.
- R10: A byte request is decoded and strobed in the cycle it is presented. `ack` rises in the next cycle. `ack_rdata` carries {0x00, byte} for a read and 0 for a write. A write drives `req_wdata[7:0]` on `mem_wdata`.
- R11: A word request accesses its address with the high data byte in the first cycle, while `busy` is 0. It accesses the address plus one, wrapping 0xFFFF to 0x0000, with the low byte in the second cycle, while `busy` is 1. `ack` follows in the cycle after that, and a read returns {first byte, second byte}.
- R12: A request presented while `busy` is 1 is ignored: it produces no strobe for its own address and no extra `ack`.
- R13: After reset, and in any cycle with no request and `busy` low, `ack`, `busy`, `mem_rd` and `mem_wr` are 0 and `region` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rom_sel | input | 1 | Selects BASIC ROM over upper RAM |
| boot_mode | input | 3 | Boot image select |
| init_en | input | 1 | Initiator ROM overlay enable |
| sub_halted | input | 1 | Sub-processor is halted |
| mem_rdata | input | 8 | Read byte from the selected region, same cycle |
| region | output | 4 | Region code of the current byte cycle |
| offset | output | 15 | Offset within the region |
| mem_rd | output | 1 | Read strobe to the region |
| mem_wr | output | 1 | Write strobe to the region |
| mem_wdata | output | 8 | Write byte to the region |
| busy | output | 1 | Second byte cycle of a word access |
| ack | output | 1 | Access complete |
| ack_rdata | output | 16 | Read result |

## Verification
The bench aims at the edges of each range, the overlays and the gated cases.

- **Range edges:** 0x7FFF/0x8000, 0xFC7F/0xFC80, 0xFFDF/0xFFE0 and 0xFFFD/0xFFFE. An off-by-one comparator would show the neighbouring region code.
- **Write protection:** writes to ROM, the reset vector, non-RAM boot images and shared RAM while the sub-processor runs must all stay unstrobed. A missing guard would corrupt a ROM model or the display processor's memory.
- **Initiator overlay:** reads inside the overlay must carry the shifted offsets, while the I/O page stays reachable. A design that covered the I/O page would leave software unable to switch the overlay off.
- **Word accesses:** word reads must return big-endian data, including a read that wraps past 0xFFFF and one that hits the fixed vector. A word access must also ignore a request that arrives in its second cycle. Swapped bytes, a missing wrap or a double acknowledge are caught there.

// File: rtl/mem_region_decoder.sv
module mem_region_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_wr,
  input  logic        req_word,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic        rom_sel,
  input  logic [2:0]  boot_mode,
  input  logic        init_en,
  input  logic        sub_halted,
  input  logic [7:0]  mem_rdata,
  output logic [3:0]  region,
  output logic [14:0] offset,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  output logic        busy,
  output logic        ack,
  output logic [15:0] ack_rdata
);

  localparam logic [3:0] RG_NONE   = 4'd0;
  localparam logic [3:0] RG_LOW    = 4'd1;
  localparam logic [3:0] RG_HIGH   = 4'd2;
  localparam logic [3:0] RG_BASIC  = 4'd3;
  localparam logic [3:0] RG_WORK   = 4'd4;
  localparam logic [3:0] RG_SHARED = 4'd5;
  localparam logic [3:0] RG_IO     = 4'd6;
  localparam logic [3:0] RG_BT_BAS = 4'd7;
  localparam logic [3:0] RG_BT_DOS = 4'd8;
  localparam logic [3:0] RG_BT_MAP = 4'd9;
  localparam logic [3:0] RG_BT_RAM = 4'd10;
  localparam logic [3:0] RG_VECT   = 4'd11;
  localparam logic [3:0] RG_RSTV   = 4'd12;
  localparam logic [3:0] RG_INIT   = 4'd13;

  logic        second;
  logic [15:0] lo_addr;
  logic [7:0]  lo_wdata;
  logic        lo_wr;
  logic [7:0]  hi_byte;

  logic        active;
  logic [15:0] a;
  logic        wr;
  logic [3:0]  rg;
  logic [14:0] off;
  logic        ro;
  logic        blocked;
  logic        forced;
  logic [7:0]  fdata;
  logic [7:0]  byte_val;

  assign active    = second | req;
  assign a         = second ? lo_addr : req_addr;
  assign wr        = second ? lo_wr : req_wr;
  assign mem_wdata = second ? lo_wdata : (req_word ? req_wdata[15:8] : req_wdata[7:0]);

  always_comb begin
    rg  = RG_NONE;
    off = '0;
    ro  = 1'b0;
    if (init_en && a[15:13] == 3'b011) begin
      rg  = RG_INIT;
      off = {2'b00, a[12:0]};
      ro  = 1'b1;
    end else if (init_en && a[15:13] == 3'b111 && a[15:8] != 8'hFD) begin
      rg  = RG_INIT;
      off = {2'b00, a[12:0]};
      ro  = 1'b1;
    end else if (!a[15]) begin
      rg  = RG_LOW;
      off = a[14:0];
    end else if (a < 16'hFC00) begin
      rg  = rom_sel ? RG_BASIC : RG_HIGH;
      off = a[14:0];
      ro  = rom_sel;
    end else if (a < 16'hFC80) begin
      rg  = RG_WORK;
      off = {8'h00, a[6:0]};
    end else if (a < 16'hFD00) begin
      rg  = RG_SHARED;
      off = {8'h00, a[6:0]};
    end else if (a < 16'hFE00) begin
      rg  = RG_IO;
      off = {7'h00, a[7:0]};
    end else if (a < 16'hFFE0) begin
      off = {6'h00, a[8:0]};
      case (boot_mode)
        3'd1:    begin rg = RG_BT_DOS; ro = 1'b1; end
        3'd2:    begin rg = RG_BT_MAP; ro = 1'b1; end
        3'd3:    rg = RG_BT_RAM;
        default: begin rg = RG_BT_BAS; ro = 1'b1; end
      endcase
    end else if (a < 16'hFFFE) begin
      rg  = RG_VECT;
      off = {10'h000, a[4:0]};
    end else begin
      rg  = RG_RSTV;
      off = {14'h0000, a[0]};
      ro  = 1'b1;
    end
  end

  assign blocked  = (rg == RG_SHARED) && !sub_halted;
  assign forced   = blocked || (rg == RG_RSTV);
  assign fdata    = (rg == RG_RSTV) ? (a[0] ? 8'h00 : 8'hFE) : 8'hFF;
  assign byte_val = forced ? fdata : mem_rdata;

  assign region = active ? rg : RG_NONE;
  assign offset = active ? off : '0;
  assign mem_rd = active && !wr && !forced;
  assign mem_wr = active && wr && !ro && !blocked;
  assign busy   = second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second    <= 1'b0;
      lo_addr   <= '0;
      lo_wdata  <= '0;
      lo_wr     <= 1'b0;
      hi_byte   <= '0;
      ack       <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (second) begin
        second    <= 1'b0;
        ack       <= 1'b1;
        ack_rdata <= lo_wr ? 16'h0000 : {hi_byte, byte_val};
      end else if (req) begin
        if (req_word) begin
          second   <= 1'b1;
          lo_addr  <= req_addr + 16'd1;
          lo_wdata <= req_wdata[7:0];
          lo_wr    <= req_wr;
          hi_byte  <= req_wr ? 8'h00 : byte_val;
        end else begin
          ack       <= 1'b1;
          ack_rdata <= req_wr ? 16'h0000 : {8'h00, byte_val};
        end
      end
    end
  end

endmodule

// File: rtl/mem_region_decoder_chk.sv
module mem_region_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        req_word,
  input logic        sub_halted,
  input logic [3:0]  region,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        busy,
  input logic        ack
);

  // R4
  p_shared_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd5 && (mem_rd || mem_wr)) |-> sub_halted);

  // R2, R6, R9: read-only regions never see a write strobe
  p_rom_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (region inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd10, 4'd11}));

  p_reset_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd12) |-> (!mem_rd && !mem_wr));

  p_byte_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && !req_word) |=> (ack && !busy));

  p_word_second_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && req_word) |=> (busy && !ack));

  p_busy_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && ack));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !busy) |-> (region == 4'd0 && !mem_rd && !mem_wr));

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind mem_region_decoder mem_region_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_word(req_word),
  .sub_halted(sub_halted), .region(region), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .busy(busy), .ack(ack)
);

// File: tb/test_mem_region_decoder.sv
module test_mem_region_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rom_sel = 1'b0;
  logic [2:0]  boot_mode = 3'd0;
  logic        init_en = 1'b0;
  logic        sub_halted = 1'b0;
  logic [7:0]  mem_rdata;
  logic [3:0]  region;
  logic [14:0] offset;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        ack;
  logic [15:0] ack_rdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign mem_rdata = {region, offset[3:0]};

  mem_region_decoder i_mem_region_decoder (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .rom_sel(rom_sel),
    .boot_mode(boot_mode), .init_en(init_en), .sub_halted(sub_halted),
    .mem_rdata(mem_rdata), .region(region), .offset(offset), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .ack(ack),
    .ack_rdata(ack_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic byte_acc(input logic [15:0] addr, input logic wr, input logic [7:0] wd,
                          input logic [3:0] e_rg, input logic [14:0] e_off,
                          input logic e_rd, input logic e_wr, input logic [15:0] e_data,
                          input string tag);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_word = 1'b0; req_addr = addr; req_wdata = {8'h5A, wd};
    #1;
    chk(tag, "region", 32'(region), 32'(e_rg));
    chk(tag, "offset", 32'(offset), 32'(e_off));
    chk(tag, "mem_rd", 32'(mem_rd), 32'(e_rd));
    chk(tag, "mem_wr", 32'(mem_wr), 32'(e_wr));
    if (wr) chk("R10", "mem_wdata", 32'(mem_wdata), 32'(wd));
    @(negedge clk);
    req = 1'b0;
    #1;
    chk("R10", "ack", 32'(ack), 32'd1);
    chk(tag, "ack_rdata", 32'(ack_rdata), 32'(e_data));
  endtask

  task automatic word_acc(input logic [15:0] addr, input logic wr, input logic [15:0] wd,
                          input logic [3:0] r0, input logic [14:0] o0,
                          input logic [3:0] r1, input logic [14:0] o1,
                          input logic [15:0] e_data, input logic poke, input string tag);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_word = 1'b1; req_addr = addr; req_wdata = wd;
    #1;
    chk(tag, "phase0 region", 32'(region), 32'(r0));
    chk(tag, "phase0 offset", 32'(offset), 32'(o0));
    chk(tag, "phase0 busy", 32'(busy), 32'd0);
    if (wr) chk(tag, "phase0 wdata", 32'(mem_wdata), 32'(wd[15:8]));
    @(negedge clk);
    if (poke) begin
      req_word = 1'b0; req_wr = 1'b0; req_addr = 16'hFC00;
    end else begin
      req = 1'b0;
    end
    #1;
    chk(tag, "phase1 busy", 32'(busy), 32'd1);
    chk(tag, "phase1 ack", 32'(ack), 32'd0);
    chk(tag, "phase1 region", 32'(region), 32'(r1));
    chk(tag, "phase1 offset", 32'(offset), 32'(o1));
    if (wr) chk(tag, "phase1 wdata", 32'(mem_wdata), 32'(wd[7:0]));
    @(negedge clk);
    req = 1'b0;
    #1;
    chk(tag, "ack", 32'(ack), 32'd1);
    chk(tag, "ack_rdata", 32'(ack_rdata), 32'(e_data));
    @(negedge clk);
    #1;
    chk(tag, "no extra ack", 32'(ack), 32'd0);
  endtask

  task automatic t_reset;
    chk("R13", "ack", 32'(ack), 32'd0);
    chk("R13", "busy", 32'(busy), 32'd0);
    chk("R13", "region", 32'(region), 32'd0);
    chk("R13", "strobes", 32'({mem_rd, mem_wr}), 32'd0);
  endtask

  task automatic t_low_ram;
    byte_acc(16'h1234, 1'b0, 8'h00, 4'd1, 15'h1234, 1'b1, 1'b0, 16'h0014, "R1");
    byte_acc(16'h7FFF, 1'b1, 8'hA5, 4'd1, 15'h7FFF, 1'b0, 1'b1, 16'h0000, "R1");
  endtask

  task automatic t_upper;
    rom_sel = 1'b0;
    byte_acc(16'h8000, 1'b0, 8'h00, 4'd2, 15'h0000, 1'b1, 1'b0, 16'h0020, "R2");
    rom_sel = 1'b1;
    byte_acc(16'hFBFF, 1'b0, 8'h00, 4'd3, 15'h7BFF, 1'b1, 1'b0, 16'h003F, "R2");
    byte_acc(16'h9000, 1'b1, 8'h11, 4'd3, 15'h1000, 1'b0, 1'b0, 16'h0000, "R2");
    rom_sel = 1'b0;
  endtask

  task automatic t_work_shared;
    sub_halted = 1'b1;
    byte_acc(16'hFC7F, 1'b0, 8'h00, 4'd4, 15'h007F, 1'b1, 1'b0, 16'h004F, "R3");
    byte_acc(16'hFC80, 1'b0, 8'h00, 4'd5, 15'h0000, 1'b1, 1'b0, 16'h0050, "R3");
    byte_acc(16'hFCFF, 1'b0, 8'h00, 4'd5, 15'h007F, 1'b1, 1'b0, 16'h005F, "R3");
    byte_acc(16'hFCA3, 1'b1, 8'h3C, 4'd5, 15'h0023, 1'b0, 1'b1, 16'h0000, "R3");
  endtask

  task automatic t_shared_gate;
    sub_halted = 1'b0;
    byte_acc(16'hFC90, 1'b0, 8'h00, 4'd5, 15'h0010, 1'b0, 1'b0, 16'h00FF, "R4");
    byte_acc(16'hFC90, 1'b1, 8'h77, 4'd5, 15'h0010, 1'b0, 1'b0, 16'h0000, "R4");
  endtask

  task automatic t_io;
    byte_acc(16'hFD0A, 1'b0, 8'h00, 4'd6, 15'h000A, 1'b1, 1'b0, 16'h006A, "R5");
    byte_acc(16'hFDFF, 1'b1, 8'h42, 4'd6, 15'h00FF, 1'b0, 1'b1, 16'h0000, "R5");
  endtask

  task automatic t_boot;
    boot_mode = 3'd0;
    byte_acc(16'hFE00, 1'b0, 8'h00, 4'd7, 15'h0000, 1'b1, 1'b0, 16'h0070, "R6");
    byte_acc(16'hFE00, 1'b1, 8'h99, 4'd7, 15'h0000, 1'b0, 1'b0, 16'h0000, "R6");
    boot_mode = 3'd1;
    byte_acc(16'hFF10, 1'b0, 8'h00, 4'd8, 15'h0110, 1'b1, 1'b0, 16'h0080, "R6");
    boot_mode = 3'd2;
    byte_acc(16'hFE05, 1'b0, 8'h00, 4'd9, 15'h0005, 1'b1, 1'b0, 16'h0095, "R6");
    boot_mode = 3'd3;
    byte_acc(16'hFFDF, 1'b0, 8'h00, 4'd10, 15'h01DF, 1'b1, 1'b0, 16'h00AF, "R6");
    byte_acc(16'hFE00, 1'b1, 8'h66, 4'd10, 15'h0000, 1'b0, 1'b1, 16'h0000, "R6");
    boot_mode = 3'd5;
    byte_acc(16'hFE01, 1'b0, 8'h00, 4'd7, 15'h0001, 1'b1, 1'b0, 16'h0071, "R6");
    boot_mode = 3'd0;
  endtask

  task automatic t_vectors;
    byte_acc(16'hFFE0, 1'b0, 8'h00, 4'd11, 15'h0000, 1'b1, 1'b0, 16'h00B0, "R7");
    byte_acc(16'hFFFD, 1'b0, 8'h00, 4'd11, 15'h001D, 1'b1, 1'b0, 16'h00BD, "R7");
    byte_acc(16'hFFE5, 1'b1, 8'h12, 4'd11, 15'h0005, 1'b0, 1'b1, 16'h0000, "R7");
    byte_acc(16'hFFFE, 1'b0, 8'h00, 4'd12, 15'h0000, 1'b0, 1'b0, 16'h00FE, "R8");
    byte_acc(16'hFFFF, 1'b0, 8'h00, 4'd12, 15'h0001, 1'b0, 1'b0, 16'h0000, "R8");
    byte_acc(16'hFFFE, 1'b1, 8'h34, 4'd12, 15'h0000, 1'b0, 1'b0, 16'h0000, "R8");
  endtask

  task automatic t_init;
    init_en = 1'b1;
    byte_acc(16'h6000, 1'b0, 8'h00, 4'd13, 15'h0000, 1'b1, 1'b0, 16'h00D0, "R9");
    byte_acc(16'h7FFF, 1'b0, 8'h00, 4'd13, 15'h1FFF, 1'b1, 1'b0, 16'h00DF, "R9");
    byte_acc(16'hE000, 1'b0, 8'h00, 4'd13, 15'h0000, 1'b1, 1'b0, 16'h00D0, "R9");
    byte_acc(16'hFFFE, 1'b0, 8'h00, 4'd13, 15'h1FFE, 1'b1, 1'b0, 16'h00DE, "R9");
    byte_acc(16'hFD05, 1'b0, 8'h00, 4'd6, 15'h0005, 1'b1, 1'b0, 16'h0065, "R9");
    byte_acc(16'h5FFF, 1'b0, 8'h00, 4'd1, 15'h5FFF, 1'b1, 1'b0, 16'h001F, "R9");
    byte_acc(16'h6000, 1'b1, 8'hEE, 4'd13, 15'h0000, 1'b0, 1'b0, 16'h0000, "R9");
    init_en = 1'b0;
  endtask

  task automatic t_words;
    word_acc(16'h1000, 1'b0, 16'h0000, 4'd1, 15'h1000, 4'd1, 15'h1001, 16'h1011, 1'b0, "R11");
    word_acc(16'hFFFE, 1'b0, 16'h0000, 4'd12, 15'h0000, 4'd12, 15'h0001, 16'hFE00, 1'b0, "R11");
    word_acc(16'hFFFF, 1'b0, 16'h0000, 4'd12, 15'h0001, 4'd1, 15'h0000, 16'h0010, 1'b0, "R11");
    word_acc(16'h2000, 1'b1, 16'hBEEF, 4'd1, 15'h2000, 4'd1, 15'h2001, 16'h0000, 1'b0, "R11");
  endtask

  task automatic t_busy_ignore;
    word_acc(16'h3000, 1'b0, 16'h0000, 4'd1, 15'h3000, 4'd1, 15'h3001, 16'h1011, 1'b1, "R12");
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_low_ram();
    t_upper();
    t_work_shared();
    t_shared_gate();
    t_io();
    t_boot();
    t_vectors();
    t_init();
    t_words();
    t_busy_ignore();
    @(negedge clk);
    #1;
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule